// File: doc/BRIEF.md
# Flash status register controller

This block keeps the eight-bit status byte of a multi-bank NOR flash and runs the small state machine behind it. The command decoder sends it one-cycle strobes: program, erase, suspend, resume, clear-status, read-status and read-array. The pulse sequencer sends it a verify result for every pulse it applies. The block accepts or rejects each operation. It counts the failing verify pulses, handles the suspend and resume handshake, and keeps error flags set until they are cleared on purpose.

The read path uses two outputs. The first is `status_q`, which is frozen for the length of each read strobe. The second is a select flag that tells the read path to return the status byte instead of array data. The flag is high when read-status mode is on. It is also high, without any command, when the addressed bank is the one with an operation in progress.

Top module: `flash_status_ctl`

## Requirements
- R1: After hardware reset (`rst_n` low), the status byte reads 0x80 and `status_sel` is 0. A reset in any later state returns to this value.
- R2: Bit 7 is 0 while an operation runs or while a suspend is still pending. It is 1 when the block is idle or suspended. `seq_active` is 1 exactly while the sequencer may keep pulsing.
- R3: A suspend that is not overtaken by completion takes effect SUSP_LATENCY cycles after it is accepted. Bit 7 then goes to 1, and bit 6 goes to 1 for an erase or bit 2 for a program. A resume clears bits 6 and 2 and returns to running, with bit 7 at 0.
- R4: If a passing verify arrives while a suspend is pending, the operation ends normally. Bits 6 and 2 stay 0 and bit 7 goes to 1.
- R5: After MAX_PULSES failing verify pulses, an erase sets bit 5 and a program sets bit 4. A pass on an earlier pulse ends the operation with no error bit set.
- R6: A program marked as writing a 1 over a programmed 0 sets bit 4 and does not start when `vpp_high` is 0. When `vpp_high` is 1, the condition is not reported and the program runs normally.
- R7: `vpp_valid` is sampled only when a program or erase is accepted. If it is 0 at that moment, bit 3 is set and nothing starts. A drop in `vpp_valid` during an operation has no effect. This check takes priority over the lock check.
- R8: A program or erase aimed at a locked bank (`op_locked` = 1) sets bit 1 and does not start.
- R9: Bits 5, 4, 3 and 1 stay set until a clear-status command or a reset. Clear-status leaves the other bits alone.
- R10: While any of bits 5, 4, 3 and 1 is set, a new program or erase is ignored: `seq_active` stays 0 and the status byte does not change.
- R11: The status byte is captured when the read strobe (`ce_n` and `oe_n` both low) begins, and held until either strobe returns high. After that, `status_q` shows the live value again.
- R12: Bit 0 is 1, and `status_sel` is forced to 1, only while an operation runs or a suspend is pending and `addr_bank` equals the bank of that operation.
- R13: A read-status command sets `status_sel` and keeps it set. A read-array command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| cmd_program | input | 1 | Program command strobe |
| cmd_erase | input | 1 | Erase command strobe |
| cmd_suspend | input | 1 | Suspend command strobe |
| cmd_resume | input | 1 | Resume command strobe |
| cmd_clear | input | 1 | Clear-status command strobe |
| cmd_read_status | input | 1 | Enter read-status mode |
| cmd_read_array | input | 1 | Leave read-status mode |
| cmd_bank | input | BW | Bank targeted by a program or erase |
| op_locked | input | 1 | Targeted block is locked |
| overwrite_one | input | 1 | Program tries to turn a 0 back into a 1 |
| vpp_valid | input | 1 | Programming supply is within range |
| vpp_high | input | 1 | Programming supply is at the high level |
| pulse_done | input | 1 | Sequencer finished one pulse and verify |
| pulse_pass | input | 1 | Verify result of that pulse |
| addr_bank | input | BW | Bank of the current read address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| seq_active | output | 1 | Sequencer may apply pulses |
| status_sel | output | 1 | Read path returns the status byte |
| status_q | output | 8 | Status byte as presented to the read path |

## Verification
The bench targets a suspend that arrives late enough for completion to win. A design that gets this wrong would report a suspended erase after it has already finished. It checks the exact cycle in which bit 7 rises after a suspend, which catches a latency counter that is off by one. It checks that error bits survive unrelated commands and block any new operation, so a design that cleared them early, or let an operation start over an error, is caught. It checks that the status byte stays frozen during a read strobe while the live value changes underneath, and that a supply drop during an operation is ignored.

// File: rtl/flash_status_ctl.sv
module flash_status_ctl #(
  parameter int NUM_BANKS    = 4,
  parameter int MAX_PULSES   = 16,
  parameter int SUSP_LATENCY = 4,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_program,
  input  logic          cmd_erase,
  input  logic          cmd_suspend,
  input  logic          cmd_resume,
  input  logic          cmd_clear,
  input  logic          cmd_read_status,
  input  logic          cmd_read_array,
  input  logic [BW-1:0] cmd_bank,
  input  logic          op_locked,
  input  logic          overwrite_one,
  input  logic          vpp_valid,
  input  logic          vpp_high,
  input  logic          pulse_done,
  input  logic          pulse_pass,
  input  logic [BW-1:0] addr_bank,
  input  logic          ce_n,
  input  logic          oe_n,
  output logic          seq_active,
  output logic          status_sel,
  output logic [7:0]    status_q
);
  localparam int CW = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1;
  localparam int LW = (SUSP_LATENCY > 1) ? $clog2(SUSP_LATENCY) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(MAX_PULSES - 1);
  localparam logic [LW-1:0] LAT_LAST = LW'(SUSP_LATENCY - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_PEND, S_SUSP} st_t;

  st_t           st;
  logic          op_erase;
  logic [BW-1:0] op_bank;
  logic [CW-1:0] cnt;
  logic [LW-1:0] lat;
  logic          e_erase, e_prog, e_vpp, e_lock;
  logic          s_esusp, s_psusp;
  logic          rs_mode, prev_low;
  logic [7:0]    latched, live;

  wire any_err    = e_erase | e_prog | e_vpp | e_lock;
  wire start_req  = (cmd_program | cmd_erase) && st == S_IDLE;
  wire working    = st == S_RUN || st == S_PEND;
  wire bank_busy  = working && addr_bank == op_bank;
  wire strobe_low = !ce_n && !oe_n;
  wire hold       = strobe_low && prev_low;

  assign live       = {st == S_IDLE || st == S_SUSP, s_esusp, e_erase, e_prog,
                       e_vpp, s_psusp, e_lock, bank_busy};
  assign seq_active = working;
  assign status_sel = rs_mode | bank_busy;
  assign status_q   = hold ? latched : live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_erase <= 1'b0;
      op_bank  <= '0;
      cnt      <= '0;
      lat      <= '0;
      e_erase  <= 1'b0;
      e_prog   <= 1'b0;
      e_vpp    <= 1'b0;
      e_lock   <= 1'b0;
      s_esusp  <= 1'b0;
      s_psusp  <= 1'b0;
    end else begin
      if (cmd_clear) begin
        e_erase <= 1'b0;
        e_prog  <= 1'b0;
        e_vpp   <= 1'b0;
        e_lock  <= 1'b0;
      end
      case (st)
        S_IDLE: begin
          if (start_req && !any_err) begin
            if (!vpp_valid)
              e_vpp <= 1'b1;
            else if (op_locked)
              e_lock <= 1'b1;
            else if (cmd_program && overwrite_one && !vpp_high)
              e_prog <= 1'b1;
            else begin
              st       <= S_RUN;
              op_erase <= cmd_erase;
              op_bank  <= cmd_bank;
              cnt      <= '0;
            end
          end
        end
        S_RUN, S_PEND: begin
          if (pulse_done) begin
            if (pulse_pass)
              st <= S_IDLE;
            else if (cnt == CNT_LAST) begin
              st <= S_IDLE;
              if (op_erase) e_erase <= 1'b1;
              else          e_prog  <= 1'b1;
            end else
              cnt <= cnt + 1'b1;
          end else if (st == S_RUN && cmd_suspend) begin
            st  <= S_PEND;
            lat <= '0;
          end else if (st == S_PEND) begin
            if (lat == LAT_LAST) begin
              st <= S_SUSP;
              if (op_erase) s_esusp <= 1'b1;
              else          s_psusp <= 1'b1;
            end else
              lat <= lat + 1'b1;
          end
        end
        S_SUSP: begin
          if (cmd_resume) begin
            st      <= S_RUN;
            s_esusp <= 1'b0;
            s_psusp <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_mode  <= 1'b0;
      prev_low <= 1'b0;
      latched  <= 8'h80;
    end else begin
      if (cmd_read_status)     rs_mode <= 1'b1;
      else if (cmd_read_array) rs_mode <= 1'b0;
      prev_low <= strobe_low;
      if (strobe_low && !prev_low) latched <= live;
    end
  end

  wire [3:0] err_now = {e_erase, e_prog, e_vpp, e_lock};

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_clear |=> ((err_now & $past(err_now)) == $past(err_now)));

  a_r10_reject_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && any_err && (cmd_program || cmd_erase)) |=> !seq_active);

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!hold || $stable(status_q)));

  a_r3_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUSP && cmd_resume) |=> (!live[6] && !live[2] && !live[7] && seq_active));

  a_r4_overtaken: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PEND && pulse_done && pulse_pass) |=> (live[7] && !live[6] && !live[2]));

  a_r2_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active |-> !live[7]);
endmodule

// File: tb/tb_flash_status_ctl.sv
`timescale 1ns/1ps
module tb_flash_status_ctl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_program = 0, cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0;
  logic cmd_clear = 0, cmd_read_status = 0, cmd_read_array = 0;
  logic [1:0] cmd_bank = 0, addr_bank = 0;
  logic op_locked = 0, overwrite_one = 0, vpp_valid = 1, vpp_high = 0;
  logic pulse_done = 0, pulse_pass = 0, ce_n = 1, oe_n = 1;
  logic seq_active, status_sel;
  logic [7:0] status_q;

  int checks = 0, errs = 0;

  flash_status_ctl dut (
    .clk(clk), .rst_n(rst_n), .cmd_program(cmd_program), .cmd_erase(cmd_erase),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_clear(cmd_clear),
    .cmd_read_status(cmd_read_status), .cmd_read_array(cmd_read_array),
    .cmd_bank(cmd_bank), .op_locked(op_locked), .overwrite_one(overwrite_one),
    .vpp_valid(vpp_valid), .vpp_high(vpp_high), .pulse_done(pulse_done),
    .pulse_pass(pulse_pass), .addr_bank(addr_bank), .ce_n(ce_n), .oe_n(oe_n),
    .seq_active(seq_active), .status_sel(status_sel), .status_q(status_q));

  // {erase, vpp_valid, vpp_high, overwrite, locked, failing pulses, expected byte}
  localparam logic [17:0] VEC [11] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  8'h80},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd5,  8'h80},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd16, 8'h90},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd15, 8'h80},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd16, 8'hA0},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  8'h88},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  8'h88},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0,  8'h90},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0,  8'h80},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd0,  8'h82},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  8'h88}
  };

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobe(ref logic s);
    s = 1'b1;
    tick();
    s = 1'b0;
  endtask

  task automatic pulse(input logic pass);
    pulse_done = 1'b1;
    pulse_pass = pass;
    tick();
    pulse_done = 1'b0;
    pulse_pass = 1'b0;
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    chk("R1 reset status", status_q, 8'h80);
    chk("R1 reset select", {7'd0, status_sel}, 8'h00);

    foreach (VEC[i]) begin
      strobe(cmd_clear);
      vpp_valid = VEC[i][16];
      vpp_high = VEC[i][15];
      overwrite_one = VEC[i][14];
      op_locked = VEC[i][13];
      if (VEC[i][17]) strobe(cmd_erase);
      else            strobe(cmd_program);
      vpp_valid = 1'b1;
      vpp_high = 1'b0;
      overwrite_one = 1'b0;
      op_locked = 1'b0;
      for (int k = 0; k < 20; k++) begin
        if (status_q[7]) break;
        pulse(k >= int'(VEC[i][12:8]));
      end
      chk($sformatf("R5/R6/R7/R8 vector %0d", i), status_q, VEC[i][7:0]);
    end

    strobe(cmd_clear);
    cmd_bank = 2'd2;
    addr_bank = 2'd2;
    strobe(cmd_erase);
    chk("R2 busy erase, own bank", status_q, 8'h01);
    chk("R2 seq_active while running", {7'd0, seq_active}, 8'h01);
    chk("R12 select forced for busy bank", {7'd0, status_sel}, 8'h01);
    addr_bank = 2'd1;
    #1;
    chk("R12 other bank bit0", status_q, 8'h00);
    chk("R12 other bank select", {7'd0, status_sel}, 8'h00);

    strobe(cmd_suspend);
    tick(3);
    chk("R3 suspend still pending", status_q, 8'h00);
    tick();
    chk("R3 erase suspended", status_q, 8'hC0);
    chk("R3 sequencer paused", {7'd0, seq_active}, 8'h00);
    strobe(cmd_resume);
    chk("R3 resumed erase", status_q, 8'h00);
    pulse(1'b1);
    chk("R3 erase finished after resume", status_q, 8'h80);

    cmd_bank = 2'd1;
    strobe(cmd_program);
    chk("R12 program busy own bank", status_q, 8'h01);
    strobe(cmd_suspend);
    tick(4);
    chk("R3 program suspended", status_q, 8'h84);
    strobe(cmd_resume);
    chk("R3 resumed program", status_q, 8'h01);
    pulse(1'b1);
    chk("R3 program done", status_q, 8'h80);

    strobe(cmd_erase);
    strobe(cmd_suspend);
    tick();
    pulse(1'b1);
    tick(5);
    chk("R4 completion overtakes suspend", status_q, 8'h80);

    strobe(cmd_program);
    vpp_valid = 1'b0;
    tick();
    pulse(1'b1);
    chk("R7 supply drop mid-op ignored", status_q, 8'h80);

    strobe(cmd_program);
    vpp_valid = 1'b1;
    chk("R7 bad supply at start", status_q, 8'h88);
    strobe(cmd_read_status);
    chk("R9 error survives other command", status_q, 8'h88);
    chk("R13 read-status select", {7'd0, status_sel}, 8'h01);
    strobe(cmd_erase);
    chk("R10 erase rejected seq_active", {7'd0, seq_active}, 8'h00);
    chk("R10 erase rejected status", status_q, 8'h88);

    ce_n = 1'b0;
    oe_n = 1'b0;
    tick(2);
    strobe(cmd_clear);
    chk("R11 byte held during strobe", status_q, 8'h88);
    oe_n = 1'b1;
    #1;
    chk("R11 live after strobe / R9 cleared", status_q, 8'h80);
    ce_n = 1'b1;
    strobe(cmd_read_array);
    chk("R13 read-array clears select", {7'd0, status_sel}, 8'h00);

    vpp_valid = 1'b0;
    strobe(cmd_program);
    vpp_valid = 1'b1;
    strobe(cmd_read_status);
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset clears error", status_q, 8'h80);
    chk("R1 reset clears select", {7'd0, status_sel}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule